// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the sync, data-enable and pixel-position signals for a raster display. Software sets it up through a small register file of 32-bit words. It programs the line and frame totals, where the horizontal and vertical sync pulses sit, how wide the blanking is, the sync polarities, an enable bit and a pixel-width select. Two counters walk through each frame. From their position the block derives hsync, vsync and data-enable, and it raises a one-cycle pulse at the start of each frame. The position and that pulse feed a downstream pixel fetch stage.

Each timing word holds two fields, each stored as the wanted value minus one. The horizontal field sits in bits 31:16 and the vertical field in bits 15:0. Timing writes go to shadow copies first. Writing 1 to the commit register arms a transfer, and the shadow copies move into the working set at the next frame boundary. While the generator is disabled, the transfer happens on the next clock.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the generator is disabled, the position is (0,0), de and frame_start are 0, hsync and vsync are 1 (the inactive level of active-low sync), fmt_xrgb is 0, and every register reads 0 except the ID word.
- R2: Word addresses 0x10 (totals), 0x14 (hsync offsets), 0x18 (vsync offsets), 0x1C (blanking), 0x40 (frame address) and 0x50 (line pitch) read back what was written. Control at 0x00 keeps only bits 4:1. Address 0x3FC always reads the fixed ID 0x7D150001 and ignores writes. Unmapped addresses read 0.
- R3: While control bit 1 is clear, pix_x and pix_y hold at 0, de and frame_start stay 0, and both syncs sit at their inactive level.
- R4: While enabled, pix_x counts up once per clock and wraps to 0 after reaching the horizontal total field. On that wrap pix_y advances by one, and pix_y wraps to 0 after the vertical total field.
- R5: frame_start is high for exactly the cycle in which the enabled generator sits at (0,0).
- R6: de is high only while pix_x < Htot−Hblank and pix_y < Vtot−Vblank, where the terms are the stored fields.
- R7: hsync is asserted while Hact+S < pix_x ≤ Hact+E, with S in bits 31:16 and E in bits 15:0 of 0x14. vsync follows the same rule on pix_y with 0x18. Control bit 4 (hsync) and bit 3 (vsync) set the asserted level: 1 means active-high and 0 means active-low.
- R8: A write with bit 0 set to 0x84 arms a pending commit, and 0x84 bit 0 reads back the pending flag. The commit copies all four shadow timing words into the working set on the edge where the generator leaves the last position of a frame, or on the next edge when disabled. Mid-frame shadow writes do not change the current frame.
- R9: Status at 0x04 bit 1 reads 1 while the generator is enabled and 0 otherwise.
- R10: fmt_xrgb follows control bit 2 (1 = 32-bit pixels, 0 = 16-bit pixels).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Active-video enable |
| frame_start | output | 1 | One-cycle pulse at position (0,0) |
| fmt_xrgb | output | 1 | Pixel width select for the fetch stage |
| pix_x | output | CW | Current column |
| pix_y | output | CW | Current line |

## Verification
The hardest case is a shadow update that lands mid-frame. The old geometry must stay in force for the rest of that frame, and the new geometry must take over exactly at the wrap. The stimulus reaches this case by rewriting the blanking word and arming the commit partway through the third frame. A cycle-accurate model in the bench predicts every output on every clock, so the first frame after the swap shows a narrower active region at exactly the right cycle. Earlier, a polarity flip during the second frame checks that sync levels invert on the very next cycle without disturbing the counters.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int          CW       = 16,
  parameter int          AW       = 10,
  parameter logic [31:0] ID_VALUE = 32'h7D15_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          frame_start,
  output logic          fmt_xrgb,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y
);

  localparam logic [AW-1:0] A_CTRL  = AW'(12'h000);
  localparam logic [AW-1:0] A_STAT  = AW'(12'h004);
  localparam logic [AW-1:0] A_TOT   = AW'(12'h010);
  localparam logic [AW-1:0] A_HS    = AW'(12'h014);
  localparam logic [AW-1:0] A_VS    = AW'(12'h018);
  localparam logic [AW-1:0] A_BLK   = AW'(12'h01C);
  localparam logic [AW-1:0] A_BUF   = AW'(12'h040);
  localparam logic [AW-1:0] A_PITCH = AW'(12'h050);
  localparam logic [AW-1:0] A_GO    = AW'(12'h084);
  localparam logic [AW-1:0] A_ID    = AW'(12'h3FC);
  localparam int            HI      = 16;

  logic [4:1]    ctrl_q;
  logic [31:0]   sh_tot, sh_hs, sh_vs, sh_blk;
  logic [31:0]   act_tot, act_hs, act_vs, act_blk;
  logic [31:0]   buf_q, pitch_q;
  logic          pend;
  logic [CW-1:0] cnt_x, cnt_y;

  wire en        = ctrl_q[1];
  wire wrap_x    = cnt_x == act_tot[HI+CW-1:HI];
  wire wrap_y    = cnt_y == act_tot[CW-1:0];
  wire frame_end = wrap_x && wrap_y;
  wire commit    = pend && (!en || frame_end);

  wire [CW-1:0] hact = act_tot[HI+CW-1:HI] - act_blk[HI+CW-1:HI];
  wire [CW-1:0] vact = act_tot[CW-1:0] - act_blk[CW-1:0];
  wire [CW:0]   hs_lo = {1'b0, hact} + {1'b0, act_hs[HI+CW-1:HI]};
  wire [CW:0]   hs_hi = {1'b0, hact} + {1'b0, act_hs[CW-1:0]};
  wire [CW:0]   vs_lo = {1'b0, vact} + {1'b0, act_vs[HI+CW-1:HI]};
  wire [CW:0]   vs_hi = {1'b0, vact} + {1'b0, act_vs[CW-1:0]};
  wire hs_on = ({1'b0, cnt_x} > hs_lo) && ({1'b0, cnt_x} <= hs_hi);
  wire vs_on = ({1'b0, cnt_y} > vs_lo) && ({1'b0, cnt_y} <= vs_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sh_tot  <= '0; sh_hs  <= '0; sh_vs  <= '0; sh_blk  <= '0;
      act_tot <= '0; act_hs <= '0; act_vs <= '0; act_blk <= '0;
      buf_q   <= '0; pitch_q <= '0;
      pend    <= 1'b0;
      cnt_x   <= '0; cnt_y  <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_CTRL:  ctrl_q  <= reg_wdata[4:1];
          A_TOT:   sh_tot  <= reg_wdata;
          A_HS:    sh_hs   <= reg_wdata;
          A_VS:    sh_vs   <= reg_wdata;
          A_BLK:   sh_blk  <= reg_wdata;
          A_BUF:   buf_q   <= reg_wdata;
          A_PITCH: pitch_q <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_we && reg_addr == A_GO && reg_wdata[0]) pend <= 1'b1;
      else if (commit)                                pend <= 1'b0;
      if (commit) begin
        act_tot <= sh_tot; act_hs <= sh_hs; act_vs <= sh_vs; act_blk <= sh_blk;
      end
      if (!en) begin
        cnt_x <= '0;
        cnt_y <= '0;
      end else if (wrap_x) begin
        cnt_x <= '0;
        cnt_y <= wrap_y ? '0 : cnt_y + 1'b1;
      end else begin
        cnt_x <= cnt_x + 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {27'd0, ctrl_q, 1'b0};
      A_STAT:  reg_rdata = {30'd0, en, 1'b0};
      A_TOT:   reg_rdata = sh_tot;
      A_HS:    reg_rdata = sh_hs;
      A_VS:    reg_rdata = sh_vs;
      A_BLK:   reg_rdata = sh_blk;
      A_BUF:   reg_rdata = buf_q;
      A_PITCH: reg_rdata = pitch_q;
      A_GO:    reg_rdata = {31'd0, pend};
      A_ID:    reg_rdata = ID_VALUE;
      default: reg_rdata = '0;
    endcase
  end

  assign de          = en && cnt_x < hact && cnt_y < vact;
  assign frame_start = en && cnt_x == '0 && cnt_y == '0;
  assign hsync       = (en && hs_on) ? ctrl_q[4] : ~ctrl_q[4];
  assign vsync       = (en && vs_on) ? ctrl_q[3] : ~ctrl_q[3];
  assign fmt_xrgb    = ctrl_q[2];
  assign pix_x       = cnt_x;
  assign pix_y       = cnt_y;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pix_x == '0 && pix_y == '0)); // R3
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_x <= act_tot[HI+CW-1:HI] && cnt_y <= act_tot[CW-1:0])); // R4
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap_x && !wrap_y) |=> (pix_x == '0 && pix_y == CW'($past(pix_y) + 1'b1))); // R4
  AST_FS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && act_tot[HI+CW-1:HI] != '0) |=> !frame_start); // R5
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> ($stable(act_tot) && $stable(act_blk) && $stable(act_hs) && $stable(act_vs))); // R8

endmodule

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hsync, vsync, de, frame_start, fmt_xrgb;
  logic [15:0] pix_x, pix_y;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disp_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
    .de(de), .frame_start(frame_start), .fmt_xrgb(fmt_xrgb),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  logic [31:0] m_ctrl = 0, s_tot = 0, s_hs = 0, s_vs = 0, s_blk = 0;
  logic [31:0] a_tot = 0, a_hs = 0, a_vs = 0, a_blk = 0;
  logic        m_pend = 0;
  logic [15:0] bx = 0, by = 0;

  localparam logic [73:0] VEC [10] = '{
    {10'h010, 32'h0009_0005, 32'h0009_0005},
    {10'h014, 32'h0000_0002, 32'h0000_0002},
    {10'h018, 32'h0000_0001, 32'h0000_0001},
    {10'h01C, 32'h0003_0001, 32'h0003_0001},
    {10'h040, 32'h8000_1000, 32'h8000_1000},
    {10'h050, 32'h0000_0040, 32'h0000_0040},
    {10'h000, 32'hFFFF_FFE4, 32'h0000_0004},
    {10'h3FC, 32'h1234_5678, 32'h7D15_0001},
    {10'h200, 32'hDEAD_BEEF, 32'h0000_0000},
    {10'h004, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic w, input logic [9:0] a, input logic [31:0] d);
    logic en, wrap, commit;
    en = m_ctrl[1];
    wrap = (bx == a_tot[31:16]) && (by == a_tot[15:0]);
    commit = m_pend && (!en || wrap);
    if (!en) begin bx = 0; by = 0; end
    else if (bx == a_tot[31:16]) begin bx = 0; by = (by == a_tot[15:0]) ? 16'd0 : by + 16'd1; end
    else bx = bx + 16'd1;
    if (commit) begin a_tot = s_tot; a_hs = s_hs; a_vs = s_vs; a_blk = s_blk; end
    if (w && a == 10'h084 && d[0]) m_pend = 1;
    else if (commit) m_pend = 0;
    if (w) begin
      case (a)
        10'h000: m_ctrl = d & 32'h1E;
        10'h010: s_tot = d;
        10'h014: s_hs = d;
        10'h018: s_vs = d;
        10'h01C: s_blk = d;
        default: ;
      endcase
    end
  endtask

  task automatic check_outputs();
    logic en, hon, von, e_hs, e_vs, e_de;
    logic [16:0] hact, vact;
    en = m_ctrl[1];
    hact = {1'b0, a_tot[31:16] - a_blk[31:16]};
    vact = {1'b0, a_tot[15:0] - a_blk[15:0]};
    hon = ({1'b0, bx} > hact + a_hs[31:16]) && ({1'b0, bx} <= hact + a_hs[15:0]);
    von = ({1'b0, by} > vact + a_vs[31:16]) && ({1'b0, by} <= vact + a_vs[15:0]);
    e_hs = (en && hon) ? m_ctrl[4] : ~m_ctrl[4];
    e_vs = (en && von) ? m_ctrl[3] : ~m_ctrl[3];
    e_de = en && ({1'b0, bx} < hact) && ({1'b0, by} < vact);
    chk("R4/R3 pix_x", {16'd0, pix_x}, {16'd0, bx});
    chk("R4/R3 pix_y", {16'd0, pix_y}, {16'd0, by});
    chk("R5 frame_start", {31'd0, frame_start}, {31'd0, en && bx == 0 && by == 0});
    chk("R6 de", {31'd0, de}, {31'd0, e_de});
    chk("R7 hsync", {31'd0, hsync}, {31'd0, e_hs});
    chk("R7 vsync", {31'd0, vsync}, {31'd0, e_vs});
    chk("R10 fmt_xrgb", {31'd0, fmt_xrgb}, {31'd0, m_ctrl[2]});
  endtask

  task automatic tick(input logic w, input logic [9:0] a, input logic [31:0] d);
    reg_we = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    model_edge(w, a, d);
    reg_we = 0;
    check_outputs();
  endtask

  task automatic rd(input string tag, input logic [9:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hsync", {31'd0, hsync}, 32'd1);
    chk("R1 vsync", {31'd0, vsync}, 32'd1);
    chk("R1 de/fs", {30'd0, de, frame_start}, 32'd0);
    chk("R1 pos", {pix_x, pix_y}, 32'd0);
    rd("R1 ctrl", 10'h000, 32'd0);
    rd("R1 totals", 10'h010, 32'd0);
    rd("R1 id", 10'h3FC, 32'h7D15_0001);
    check_outputs();

    // R2 table walk
    foreach (VEC[i]) begin
      tick(1, VEC[i][73:64], VEC[i][63:32]);
      rd("R2 readback", VEC[i][73:64], VEC[i][31:0]);
    end
    chk("R10 fmt set", {31'd0, fmt_xrgb}, 32'd1);
    tick(1, 10'h000, 32'h0);
    chk("R10 fmt clear", {31'd0, fmt_xrgb}, 32'd0);

    // R8 pending flag, commit while disabled
    tick(1, 10'h084, 32'h1);
    rd("R8 pending set", 10'h084, 32'd1);
    tick(0, 10'h000, 32'h0);
    rd("R8 pending cleared", 10'h084, 32'd0);
    rd("R9 idle status", 10'h004, 32'd0);
    for (int i = 0; i < 5; i++) tick(0, 10'h000, 32'h0); // R3 idle

    // enable, two frames, polarity flip, then mid-frame shadow change
    tick(1, 10'h000, 32'h06);
    rd("R9 busy status", 10'h004, 32'd2);
    for (int i = 0; i < 260; i++) begin
      if (i == 70)       tick(1, 10'h000, 32'h1E);          // R7 polarity change
      else if (i == 140) tick(1, 10'h01C, 32'h0005_0001);   // R8 mid-frame write
      else if (i == 141) tick(1, 10'h084, 32'h1);
      else               tick(0, 10'h000, 32'h0);
    end
    rd("R2 shadow blk", 10'h01C, 32'h0005_0001);

    // disable mid-frame: R3
    for (int i = 0; i < 7; i++) tick(0, 10'h000, 32'h0);
    tick(1, 10'h000, 32'h18);
    for (int i = 0; i < 6; i++) tick(0, 10'h000, 32'h0);
    rd("R9 status after disable", 10'h004, 32'd0);

    finish_run();
  end
endmodule